// File: doc/BRIEF.md
# Dual-Direction Latched/Clocked Bus Transceiver

This block carries a data word between two ports, A and B, with one storage word per direction. Each direction has its own latch enable, its own data clock and its own output enable. With the latch enable high the path is transparent and the far side follows the near side in the same cycle. With the latch enable low the path holds its stored word, and it reloads only on a rising edge of its data clock. The two directions use opposite output-enable polarities: active high toward B, active low toward A.

The block is synchronous to a system clock `clk`. The per-direction data clocks are sampled on that clock. A rising data-clock edge is a cycle in which the data clock is sampled high after it was sampled low in the previous cycle. Each port is split into an input word, an output word with its enable, and a resolved pin view. The external driver's enable is an input. When `BUS_HOLD` is set, a keeper register per port records the last level driven onto the pin. It supplies that level whenever neither side drives the pin.

Top module: `dual_reg_xcvr`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle. The A-to-B store loads `a_in` at every system clock edge. The B-to-A path behaves the same way with `ba_le`, `b_in` and `a_out`.
- R2: While `ab_le` is 0 and no rising edge of `ab_clk` is seen, `b_out` keeps its value whatever `a_in` does.
- R3: While `ab_le` is 0, a system clock edge that samples `ab_clk` high after it was sampled low in the previous cycle loads `a_in` into the store. `b_out` shows the new word from the next cycle on.
- R4: `b_out_en` is 1 exactly when `ab_oe` is 1 (active high). While it is 0, the B pin is not driven by the block.
- R5: `a_out_en` is 1 exactly when `ba_oe_n` is 0 (active low). The B-to-A data path mirrors R1 to R3 using `ba_le` and `ba_clk`.
- R6: If the latch enable falls while the data clock is high, no load occurs until the data clock has been sampled low and then high again. That later rising edge loads the current input.
- R7: With `BUS_HOLD` = 1, each pin view shows the block's output while its enable is 1. It shows the external input while the external driver enable is 1. When neither drives, it shows the last driven level, which the keeper captured at the final driven clock edge.
- R8: Asynchronous reset clears both keepers to 0, so undriven pins read 0 after reset. Reset marks both data clocks as last sampled high, so a data clock that is high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Level present on the A pins from outside |
| a_ext_drv | input | 1 | External agent is driving the A pins |
| b_in | input | WIDTH | Level present on the B pins from outside |
| b_ext_drv | input | 1 | External agent is driving the B pins |
| ab_le | input | 1 | A-to-B latch enable, transparent when 1 |
| ab_clk | input | 1 | A-to-B data clock, loads on a rising edge |
| ab_oe | input | 1 | B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, transparent when 1 |
| ba_clk | input | 1 | B-to-A data clock, loads on a rising edge |
| ba_oe_n | input | 1 | A output enable, active low |
| b_out | output | WIDTH | Word the block drives toward B |
| b_out_en | output | 1 | Block drives the B pins |
| a_out | output | WIDTH | Word the block drives toward A |
| a_out_en | output | 1 | Block drives the A pins |
| a_pin | output | WIDTH | Resolved A pin level, including the keeper |
| b_pin | output | WIDTH | Resolved B pin level, including the keeper |

## Verification
Two functions can fall in one cycle: the release of a port by its last driver, and the keeper's capture of that driver's level. The bench provokes this by turning an output enable or an external driver off exactly one cycle after a new word was loaded or driven. It judges the pin against a behavioural model that records the keeper level at each driven edge. A second coincidence is a latch-enable fall while the data clock is high. The bench checks that only the following low-then-high clock sequence reloads the store. A long random phase mixes both coincidences with every control pattern. It also flags any cycle in which the block and the external agent drive the same port together.

// File: rtl/dual_reg_xcvr_pkg.sv
package dual_reg_xcvr_pkg;
  typedef struct packed {
    logic le;
    logic dclk;
    logic oe;
  } path_ctrl_t;
endpackage

// File: rtl/xcvr_path.sv
module xcvr_path
  import dual_reg_xcvr_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  input  path_ctrl_t       ctrl,
  output logic [WIDTH-1:0] q_out,
  output logic             drive_en
);
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;
  logic             dclk_q;
  logic             rise;
  logic             load;

  always_comb begin
    rise    = ctrl.dclk & ~dclk_q;
    load    = ctrl.le | rise;
    store_d = load ? d_in : store_q;
    q_out   = ctrl.le ? d_in : store_q;
  end

  generate
    if (OE_LOW) begin : g_oe_low
      assign drive_en = ~ctrl.oe;
    end else begin : g_oe_high
      assign drive_en = ctrl.oe;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b1;
    else        dclk_q <= ctrl.dclk;
  end

  always_ff @(posedge clk) begin
    if (load) store_q <= store_d;
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.le |=> store_q == $past(d_in));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.le && !(ctrl.dclk && !$past(ctrl.dclk))) |=> $stable(store_q));
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.le && $rose(ctrl.dclk)) |=> q_out == $past(d_in) || ctrl.le);
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int WIDTH = 18,
  parameter bit EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             own_en,
  input  logic [WIDTH-1:0] own_val,
  input  logic             ext_en,
  input  logic [WIDTH-1:0] ext_val,
  output logic [WIDTH-1:0] pin
);
  logic [WIDTH-1:0] keep_q;
  logic [WIDTH-1:0] keep_d;
  logic             driven;

  always_comb begin
    driven = own_en | ext_en;
    if (own_en)      keep_d = own_val;
    else if (ext_en) keep_d = ext_val;
    else             keep_d = keep_q;
    pin = driven ? keep_d : keep_q;
  end

  generate
    if (EN) begin : g_keep
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      keep_q <= '0;
        else if (driven) keep_q <= keep_d;
      end
    end else begin : g_nokeep
      assign keep_q = '0;
    end
  endgenerate

  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (EN && !driven) |=> (own_en || ext_en || $stable(pin)));
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import dual_reg_xcvr_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter bit BUS_HOLD = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic             a_ext_drv,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_ext_drv,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ab_oe,
  input  logic             ba_le,
  input  logic             ba_clk,
  input  logic             ba_oe_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_out_en,
  output logic [WIDTH-1:0] a_out,
  output logic             a_out_en,
  output logic [WIDTH-1:0] a_pin,
  output logic [WIDTH-1:0] b_pin
);
  path_ctrl_t ab_ctrl;
  path_ctrl_t ba_ctrl;

  always_comb begin
    ab_ctrl = '{le: ab_le, dclk: ab_clk, oe: ab_oe};
    ba_ctrl = '{le: ba_le, dclk: ba_clk, oe: ba_oe_n};
  end

  xcvr_path #(.WIDTH(WIDTH), .OE_LOW(1'b0)) u_ab (
    .clk(clk), .rst_n(rst_n), .d_in(a_in), .ctrl(ab_ctrl),
    .q_out(b_out), .drive_en(b_out_en));

  xcvr_path #(.WIDTH(WIDTH), .OE_LOW(1'b1)) u_ba (
    .clk(clk), .rst_n(rst_n), .d_in(b_in), .ctrl(ba_ctrl),
    .q_out(a_out), .drive_en(a_out_en));

  xcvr_keeper #(.WIDTH(WIDTH), .EN(BUS_HOLD)) u_keep_a (
    .clk(clk), .rst_n(rst_n), .own_en(a_out_en), .own_val(a_out),
    .ext_en(a_ext_drv), .ext_val(a_in), .pin(a_pin));

  xcvr_keeper #(.WIDTH(WIDTH), .EN(BUS_HOLD)) u_keep_b (
    .clk(clk), .rst_n(rst_n), .own_en(b_out_en), .own_val(b_out),
    .ext_en(b_ext_drv), .ext_val(b_in), .pin(b_pin));

  assert_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe && !b_ext_drv && BUS_HOLD) |=> (b_out_en || b_ext_drv || $stable(b_pin)));
  assert_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_oe_n && !a_ext_drv && BUS_HOLD) |=> (a_out_en || a_ext_drv || $stable(a_pin)));
endmodule

// File: tb/dual_reg_xcvr_tb_top.sv
module dual_reg_xcvr_tb_top;
  localparam int W = 18;
  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b_in;
  logic a_ext_drv, b_ext_drv, ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n;
  logic [W-1:0] b_out, a_out, a_pin, b_pin;
  logic b_out_en, a_out_en;

  int checks = 0;
  int failures = 0;

  logic [W-1:0] st_ab, st_ba, hold_a, hold_b;
  bit st_ab_v, st_ba_v, hold_a_v, hold_b_v, p_ab, p_ba;

  always #5 clk = ~clk;

  dual_reg_xcvr #(.WIDTH(W), .BUS_HOLD(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ext_drv(a_ext_drv),
    .b_in(b_in), .b_ext_drv(b_ext_drv), .ab_le(ab_le), .ab_clk(ab_clk),
    .ab_oe(ab_oe), .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_out_en(b_out_en), .a_out(a_out), .a_out_en(a_out_en),
    .a_pin(a_pin), .b_pin(b_pin));

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [W-1:0] eb, ea;
    bit vb, va;
    eb = ab_le ? a_in : st_ab;  vb = ab_le || st_ab_v;
    ea = ba_le ? b_in : st_ba;  va = ba_le || st_ba_v;
    chk("R4 b_out_en", {17'd0, b_out_en}, {17'd0, ab_oe});
    chk("R5 a_out_en", {17'd0, a_out_en}, {17'd0, !ba_oe_n});
    if (vb) chk(ab_le ? "R1 b_out" : "R3 b_out", b_out, eb);
    if (va) chk(ba_le ? "R1 a_out" : "R5 a_out", a_out, ea);
    if (b_out_en) begin
      if (vb) chk("R7 b_pin own", b_pin, eb);
    end else if (b_ext_drv) chk("R7 b_pin ext", b_pin, b_in);
    else if (hold_b_v) chk("R7 b_pin kept", b_pin, hold_b);
    if (a_out_en) begin
      if (va) chk("R7 a_pin own", a_pin, ea);
    end else if (a_ext_drv) chk("R7 a_pin ext", a_pin, a_in);
    else if (hold_a_v) chk("R7 a_pin kept", a_pin, hold_a);
    if ((a_out_en && a_ext_drv) || (b_out_en && b_ext_drv)) begin
      checks++; failures++;
      $display("FAIL R4 contention actual=1 expected=0");
    end
  endtask

  task automatic model_edge();
    logic [W-1:0] eb, ea;
    bit vb, va;
    eb = ab_le ? a_in : st_ab;  vb = ab_le || st_ab_v;
    ea = ba_le ? b_in : st_ba;  va = ba_le || st_ba_v;
    if (b_out_en) begin hold_b = eb; hold_b_v = vb; end
    else if (b_ext_drv) begin hold_b = b_in; hold_b_v = 1; end
    if (a_out_en) begin hold_a = ea; hold_a_v = va; end
    else if (a_ext_drv) begin hold_a = a_in; hold_a_v = 1; end
    if (ab_le || (ab_clk && !p_ab)) begin st_ab = a_in; st_ab_v = 1; end
    if (ba_le || (ba_clk && !p_ba)) begin st_ba = b_in; st_ba_v = 1; end
    p_ab = ab_clk; p_ba = ba_clk;
  endtask

  task automatic tick();
    #1 check_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; a_in = '0; b_in = '0; a_ext_drv = 0; b_ext_drv = 0;
    ab_le = 0; ab_clk = 1; ab_oe = 0; ba_le = 0; ba_clk = 1; ba_oe_n = 1;
    st_ab_v = 0; st_ba_v = 0; hold_a = '0; hold_b = '0;
    hold_a_v = 1; hold_b_v = 1; p_ab = 1; p_ba = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R8 a_pin reset", a_pin, '0);
    chk("R8 b_pin reset", b_pin, '0);
    tick();
    // R8: clock high at reset release loaded nothing; check via edge next
    ab_le = 1; ab_oe = 1; a_in = 18'h0ABCD; tick();
    chk("R1 transparent", b_out, 18'h0ABCD);
    a_in = 18'h3FFFF; #1 chk("R1 same cycle", b_out, 18'h3FFFF);
    tick();
    ab_le = 0; a_in = 18'h00001; tick();
    chk("R2 hold after le fall", b_out, 18'h3FFFF);
    a_in = 18'h12345; tick();
    chk("R6 no load while clock high", b_out, 18'h3FFFF);
    ab_clk = 0; tick();
    chk("R2 clock low no load", b_out, 18'h3FFFF);
    ab_clk = 1; a_in = 18'h2AAAA; #1 chk("R6 before edge", b_out, 18'h3FFFF);
    tick();
    a_in = 18'h15555; #1 chk("R3 captured", b_out, 18'h2AAAA);
    tick();
    ab_oe = 0; #1 chk("R4 disabled", {17'd0, b_out_en}, 18'd0);
    chk("R7 b kept", b_pin, 18'h2AAAA);
    tick();
    b_ext_drv = 1; b_in = 18'h00F0F; tick();
    b_ext_drv = 0; #1 chk("R7 b kept ext", b_pin, 18'h00F0F);
    tick();
    ba_le = 1; ba_oe_n = 0; b_in = 18'h13579; b_ext_drv = 1; #1
    chk("R5 a_out", a_out, 18'h13579);
    chk("R5 a_out_en", {17'd0, a_out_en}, 18'd1);
    tick();
    ba_oe_n = 1; #1 chk("R7 a kept", a_pin, 18'h13579);
    tick();
    for (int i = 0; i < 4000; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      ab_le = ($urandom % 4) == 0; ba_le = ($urandom % 4) == 0;
      ab_clk = $urandom; ba_clk = $urandom;
      ab_oe = $urandom; ba_oe_n = $urandom;
      a_ext_drv = ba_oe_n ? ($urandom % 2 == 1) : 1'b0;
      b_ext_drv = ab_oe ? 1'b0 : ($urandom % 2 == 1);
      tick();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule